// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a free-running 24-bit down-counter that produces a steady heartbeat for an operating-system scheduler. Software sets a period through a small word-addressed register bus. The counter then decrements on each counter clock, and the counter clock is either every core clock cycle or every pulse on an external reference tick input. Each time the count runs out, the block reloads it, latches a sticky event flag, and can issue a one-cycle interrupt request.

Software writes the period minus one to the reload register and then turns the timer on through the control register. It can poll the event flag, which is cleared when it is read, or it can take the interrupt. Writing the current-value register restarts the period. A reload value of zero makes the timer halt after its next expiry.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read 0 and `irq` is low.
- R2: Register offsets: 0x0 control, 0x4 reload, 0x8 current value, 0xC calibration. In control, bit 0 is enable, bit 1 is interrupt enable, bit 2 selects the counter clock, and bit 16 is the event flag. A write to control changes only bits 2:0. Bit 16 cannot be written, and all other bits read 0.
- R3: Reload and current value are 24 bits wide, and bits 31:24 read as 0 whatever was written.
- R4: When the count steps from 1 to 0 (an expiry), the event flag is set. If interrupt enable is 1, `irq` is high for exactly the following clock cycle. If it is 0, `irq` stays low.
- R5: A count of 0 loads the reload value on the next counter clock. The interval between expiries is therefore reload+1 counter clocks. Starting from a count of 0, the first expiry comes reload+1 counter clocks after enable.
- R6: Control bit 2 = 1 makes every core clock cycle a counter clock. Control bit 2 = 0 makes each cycle with `ref_tick` high a counter clock.
- R7: A read of control returns the event flag and clears it. If an expiry falls in the same cycle as that read, the flag stays set.
- R8: A write of any data to the current-value register sets the count to 0 and clears the event flag, and it takes precedence over a counter clock in the same cycle. The next counter clock loads the reload value.
- R9: If the reload value is 0 at an expiry, the enable bit clears and no further expiry occurs.
- R10: While enable is 0, the current value reads 0 and the internal count is held. Re-enabling resumes from the held count.
- R11: The calibration register reads the decimal constant 10000. Unaligned or unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read of control clears the event flag |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| ref_tick | input | 1 | External reference tick, one cycle high per tick |
| irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
Two pairs of actions can land on the same clock edge. An expiry can meet a read of control, and a counter clock can meet a write of the current value. To provoke the first, the bench counts reload+1 cycles after one interrupt and issues a status read whose edge is the next expiry. It judges the result by requiring that this read return a clear flag and that the read right after it return the flag set. To provoke the second, the bench writes the current value while the core clock steps the count every cycle. It judges the result by the restarted interval to the next interrupt, which must be one cycle longer than if the step had won.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_CAL  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_load;
    logic wr_cur;
    logic rd_ctrl;
  } strobe_t;

  localparam int CTL_EN   = 0;
  localparam int CTL_INT  = 1;
  localparam int CTL_SRC  = 2;
  localparam int CTL_FLAG = 16;
  localparam int CTL_W    = 3;

  // A counter clock happens when enabled and the chosen source fires.
  function automatic logic counter_step(input logic en, input logic use_core,
                                        input logic ref_pulse);
    return en & (use_core | ref_pulse);
  endfunction

endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode #(
  parameter int ADDR_W = 4
) (
  input  logic              [ADDR_W-1:0] addr,
  input  logic                           wr,
  input  logic                           rd,
  output tt_pkg::strobe_t                stb,
  output tt_pkg::reg_sel_e               sel,
  output logic                           hit
);
  import tt_pkg::*;

  localparam int WORD_LSB = 2;

  always_comb begin
    hit = (addr[WORD_LSB-1:0] == '0) && ((addr >> 4) == '0);
    sel = reg_sel_e'(addr[WORD_LSB+1:WORD_LSB]);
    stb.wr_ctrl = wr && hit && (sel == SEL_CTRL);
    stb.wr_load = wr && hit && (sel == SEL_LOAD);
    stb.wr_cur  = wr && hit && (sel == SEL_CUR);
    stb.rd_ctrl = rd && hit && (sel == SEL_CTRL);
  end

endmodule

// File: rtl/tt_ctrl_regs.sv
module tt_ctrl_regs #(
  parameter int CNT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tt_pkg::strobe_t         stb,
  input  logic [tt_pkg::CTL_W-1:0] ctrl_wdata,
  input  logic [CNT_W-1:0]        load_wdata,
  input  logic                    expire,
  input  logic                    stop_req,
  output logic                    en,
  output logic                    inten,
  output logic                    use_core,
  output logic                    flag,
  output logic [CNT_W-1:0]        reload
);
  import tt_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      inten    <= 1'b0;
      use_core <= 1'b0;
    end else if (stb.wr_ctrl) begin
      en       <= ctrl_wdata[CTL_EN];
      inten    <= ctrl_wdata[CTL_INT];
      use_core <= ctrl_wdata[CTL_SRC];
    end else if (stop_req) begin
      en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           reload <= '0;
    else if (stb.wr_load) reload <= load_wdata;
  end

  // Set by an expiry wins over a clear by read or by current-value write.
  always_ff @(posedge clk) begin
    if (!rst_n)                          flag <= 1'b0;
    else if (expire)                     flag <= 1'b1;
    else if (stb.rd_ctrl || stb.wr_cur)  flag <= 1'b0;
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rd_ctrl && !expire) |=> !flag);

  a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stb.wr_ctrl) |=> !en);

endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             stop_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rl);
    return (cur == '0) ? rl : cur - ONE;
  endfunction

  logic live_step;
  assign live_step = step && !clr;
  assign expire    = live_step && (count == ONE);
  assign stop_req  = expire && (reload == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         count <= '0;
    else if (clr)       count <= '0;
    else if (live_step) count <= next_count(count, reload);
  end

  a_r5_load_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (live_step && count == '0) |=> (count == $past(reload)));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(count));

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic              irq
);
  import tt_pkg::*;

  strobe_t          stb;
  reg_sel_e         sel;
  logic             hit;
  logic             en, inten, use_core, flag;
  logic [CNT_W-1:0] reload, count;
  logic             step, expire, stop_req;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  tt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .stb(stb), .sel(sel), .hit(hit)
  );

  tt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .ctrl_wdata(bus_wdata[CTL_W-1:0]), .load_wdata(bus_wdata[CNT_W-1:0]),
    .expire(expire), .stop_req(stop_req),
    .en(en), .inten(inten), .use_core(use_core), .flag(flag), .reload(reload)
  );

  assign step = counter_step(en, use_core, ref_tick);

  tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(stb.wr_cur), .reload(reload),
    .count(count), .expire(expire), .stop_req(stop_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= expire && inten;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_CTRL: begin
          bus_rdata[CTL_EN]   = en;
          bus_rdata[CTL_INT]  = inten;
          bus_rdata[CTL_SRC]  = use_core;
          bus_rdata[CTL_FLAG] = flag;
        end
        SEL_LOAD: bus_rdata[CNT_W-1:0] = reload;
        SEL_CUR:  if (en) bus_rdata[CNT_W-1:0] = count;
        SEL_CAL:  bus_rdata = DATA_W'(CAL_VALUE);
        default:  bus_rdata = '0;
      endcase
    end
  end

  a_r4_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  a_r4_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic ref_mode = 1'b0;
  int ref_div = 0;

  localparam int REF_PERIOD = 4;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ref_div  = (ref_div + 1) % REF_PERIOD;
    ref_tick = ref_mode && (ref_div == 0);
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    bus_read(a, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 2000);
  endtask

  task automatic clean();
    bus_write(4'h0, 32'h0);
    bus_write(4'h8, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 calibration
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    expect_read(4'h0, 32'h0, "R1 control reset");
    expect_read(4'h4, 32'h0, "R1 reload reset");
    expect_read(4'h8, 32'h0, "R1 current reset");
    expect_read(4'hC, 32'd10000, "R11 calibration");
    expect_read(4'h2, 32'h0, "R11 unaligned offset");

    // R2 control field write masking, R3 width masking
    bus_write(4'h0, 32'hFFFF_FFF8);
    expect_read(4'h0, 32'h0, "R2 only bits 2:0 writable");
    bus_write(4'h0, 32'h6);
    expect_read(4'h0, 32'h6, "R2 control fields");
    bus_write(4'h4, 32'hFFFF_FFFF);
    expect_read(4'h4, 32'h00FF_FFFF, "R3 reload upper bits");
    clean();

    // R5 sweep of periods with the core clock, R4 pulse width, R7 read clear
    for (int r = 1; r <= 8; r++) begin
      bus_write(4'h4, 32'(r));
      bus_write(4'h0, 32'h7);
      wait_irq(n);
      check(n == r + 1, $sformatf("R5 first expiry reload=%0d", r), n, r + 1);
      @(negedge clk);
      check(irq == 1'b0, "R4 irq one cycle", irq, 0);
      wait_irq(n);
      check(n == r, $sformatf("R5 period reload=%0d", r), n + 1, r + 1);
      bus_write(4'h0, 32'h0);
      expect_read(4'h0, 32'h0001_0000, "R7 flag reads set");
      expect_read(4'h0, 32'h0, "R7 flag cleared by read");
      expect_read(4'h8, 32'h0, "R10 current reads 0 when disabled");
      bus_write(4'h8, 32'h0);
    end

    // R5 count sequence
    bus_write(4'h4, 32'd6);
    bus_write(4'h0, 32'h7);
    expect_read(4'h8, 32'd0, "R5 count before load");
    expect_read(4'h8, 32'd6, "R5 count loaded");
    expect_read(4'h8, 32'd5, "R5 count decrements");
    clean();

    // R6 reference tick source
    ref_mode = 1'b1;
    bus_write(4'h4, 32'd3);
    bus_write(4'h0, 32'h3);
    wait_irq(n);
    wait_irq(n);
    check(n == 4 * REF_PERIOD, "R6 reference tick period", n, 4 * REF_PERIOD);
    wait_irq(n);
    check(n == 4 * REF_PERIOD, "R6 reference tick period again", n, 4 * REF_PERIOD);
    ref_mode = 1'b0;
    clean();

    // R4 interrupt enable off: flag sets, irq stays low
    bus_write(4'h4, 32'd3);
    bus_write(4'h0, 32'h5);
    highs = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq) highs++;
    end
    check(highs == 0, "R4 no irq when disabled", highs, 0);
    bus_write(4'h0, 32'h4);
    expect_read(4'h0, 32'h0001_0004, "R4 flag set without irq");
    clean();

    // R8 write to current value restarts period and clears flag
    bus_write(4'h4, 32'd5);
    bus_write(4'h0, 32'h7);
    wait_irq(n);
    @(negedge clk);
    @(negedge clk);
    bus_write(4'h8, 32'hDEAD);
    expect_read(4'h0, 32'h7, "R8 flag cleared by current write");
    wait_irq(n);
    check(n == 5, "R8 period restarts from write", n + 1, 6);

    // R7 expiry in the same cycle as a status read
    expect_read(4'h0, 32'h0001_0007, "R7 flag after expiry");
    repeat (4) @(negedge clk);
    expect_read(4'h0, 32'h7, "R7 read at expiry edge returns old flag");
    check(irq == 1'b1, "R4 irq at coincident expiry", irq, 1);
    expect_read(4'h0, 32'h0001_0007, "R7 set wins over clear");
    clean();

    // R9 zero reload stops the timer
    bus_write(4'h4, 32'd4);
    bus_write(4'h0, 32'h7);
    wait_irq(n);
    bus_write(4'h4, 32'd0);
    wait_irq(n);
    check(n == 4, "R9 final period uses old reload", n + 1, 5);
    expect_read(4'h0, 32'h0001_0006, "R9 enable cleared");
    expect_read(4'h8, 32'h0, "R9 current after stop");
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq) highs++;
    end
    check(highs == 0, "R9 no further expiry", highs, 0);
    clean();

    // R10 count held while disabled
    bus_write(4'h4, 32'd10);
    bus_write(4'h0, 32'h7);
    repeat (3) @(negedge clk);
    bus_write(4'h0, 32'h6);
    expect_read(4'h8, 32'h0, "R10 reads 0 while disabled");
    bus_write(4'h0, 32'h7);
    expect_read(4'h8, 32'd7, "R10 count held and resumed");
    clean();

    finish_run();
  end

endmodule